// File: doc/BRIEF.md
# Adaptive Minimal Route Selector

This block decides where a header flit goes next in a two-dimensional mesh router. It compares the current node coordinates with the target coordinates. It then takes the set of minimal directions and removes any direction that the selected turn model forbids. If two directions remain, it picks one using the load of the output links. Four turn models can be chosen at run time: west-first, east-last, negative-first and a column-alternating odd/even model. Payload flits do not pass through this logic. Storing the decision and managing tags belong to other blocks.

A request is presented for one cycle with `hdr_valid` high. One clock later the chosen direction appears on a registered output. The load inputs are the number of occupied tag slots on each mesh output link and the fill level of the FIFO in each neighbouring router. These two inputs drive the choice between the two legal directions.

Top module: `route_selector`

## Requirements
- R1: While `rst` is high, and in the cycle after it has been sampled high, `sel_valid` is 0 and `sel_dir` is 0 (Local).
- R2: `sel_valid` equals `hdr_valid` delayed by one clock. `sel_dir` takes a new value only in the cycle after `hdr_valid` is high, and holds its value otherwise.
- R3: Directions are encoded as Local=0, East=1, North=2, West=3, South=4. East is +X and North is +Y. When the target equals the current node, the result is Local. When only one axis differs, the result is the single minimal direction on that axis, in every mode.
- R4: In mode 0 (west-first), with both offsets nonzero, a target west of the node always gives West. A target east of the node is decided adaptively between the X and Y directions.
- R5: In mode 1 (east-last), with both offsets nonzero, a target east of the node gives the Y direction. A target west of the node is adaptive.
- R6: In mode 3 (negative-first), a north-west target gives West and a south-east target gives South. North-east and south-west targets are adaptive.
- R7: In mode 2 (odd/even), an even current column follows the R5 rules. An odd column follows the R4 rules, except that an eastward target more than one column away gives the Y direction. An eastward target exactly one column away stays adaptive.
- R8: In an adaptive decision, the direction whose link has fewer used slots wins. `link_used[d-1]` holds the count for direction code d.
- R9: If the slot counts are equal, the direction whose neighbour FIFO holds fewer entries wins. `nbr_fill[d-1]` holds the fill level for direction code d.
- R10: If both counts are equal, the direction that continues straight wins. Straight means the output opposite the arrival port `in_port`, which uses the same codes as R3. If neither direction is straight, the X direction wins.
- R11: The result never moves away from the target on either axis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | A header request is present this cycle |
| cur_x | input | XW | X coordinate of this node |
| cur_y | input | YW | Y coordinate of this node |
| dst_x | input | XW | Target X coordinate |
| dst_y | input | YW | Target Y coordinate |
| mode | input | 2 | Turn model: 0 west-first, 1 east-last, 2 odd/even, 3 negative-first |
| in_port | input | 3 | Port the header arrived on (R3 codes) |
| link_used | input | 4*SW | Used slot count per mesh output, index = direction code - 1 |
| nbr_fill | input | 4*FW | Neighbour FIFO fill per mesh output, index = direction code - 1 |
| sel_valid | output | 1 | Registered result valid |
| sel_dir | output | 3 | Registered chosen direction (R3 codes) |

## Verification
The hardest case to reach from the ports is the third-level tiebreak. It needs an adaptive quadrant, equal slot counts and equal FIFO fills on the two candidate links, and an arrival port that makes one candidate straight. Directed requests fix the load vectors to equal values and sweep the arrival port. This covers both the straight-Y outcome and the X fallback. The odd-column boundary, where the target is exactly one or two columns east, also gets directed requests. A long run of generated requests then draws on small value ranges for the counts, so that ties happen often.

// File: rtl/rsel_pkg.sv
package rsel_pkg;

  typedef enum logic [2:0] {
    DIR_LOCAL = 3'd0,
    DIR_EAST  = 3'd1,
    DIR_NORTH = 3'd2,
    DIR_WEST  = 3'd3,
    DIR_SOUTH = 3'd4
  } dir_e;

  typedef enum logic [1:0] {
    MODE_WEST_FIRST = 2'd0,
    MODE_EAST_LAST  = 2'd1,
    MODE_ODD_EVEN   = 2'd2,
    MODE_NEG_FIRST  = 2'd3
  } mode_e;

  // Candidate set handed from the turn filter to the tiebreak stage
  typedef struct packed {
    dir_e x_dir;
    dir_e y_dir;
    logic adaptive;
    dir_e fixed;
  } cand_t;

  // Output that keeps a flit moving in the same direction it arrived
  function automatic dir_e straight_of(input dir_e arrived);
    case (arrived)
      DIR_EAST:  return DIR_WEST;
      DIR_WEST:  return DIR_EAST;
      DIR_NORTH: return DIR_SOUTH;
      DIR_SOUTH: return DIR_NORTH;
      default:   return DIR_LOCAL;
    endcase
  endfunction

endpackage

// File: rtl/rsel_axis_delta.sv
module rsel_axis_delta #(
  parameter int W = 3
) (
  input  logic [W-1:0]      cur,
  input  logic [W-1:0]      dst,
  output logic signed [W:0] delta
);
  always_comb delta = $signed({1'b0, dst}) - $signed({1'b0, cur});
endmodule

// File: rtl/rsel_turn_filter.sv
module rsel_turn_filter #(
  parameter int XW = 3,
  parameter int YW = 3
) (
  input  logic signed [XW:0] dx,
  input  logic signed [YW:0] dy,
  input  logic               col_odd,
  input  rsel_pkg::mode_e    mode,
  output rsel_pkg::cand_t    cand
);
  import rsel_pkg::*;

  logic dx_pos, dx_neg, dx_far, dy_pos, dy_neg;
  logic use_el, use_wf;

  always_comb begin
    dx_pos = dx > 0;
    dx_neg = dx < 0;
    dx_far = dx > 1;
    dy_pos = dy > 0;
    dy_neg = dy < 0;
    use_el = (mode == MODE_EAST_LAST)  || (mode == MODE_ODD_EVEN && !col_odd);
    use_wf = (mode == MODE_WEST_FIRST) || (mode == MODE_ODD_EVEN &&  col_odd);

    cand.x_dir    = dx_pos ? DIR_EAST : DIR_WEST;
    cand.y_dir    = dy_pos ? DIR_NORTH : DIR_SOUTH;
    cand.adaptive = 1'b0;
    cand.fixed    = DIR_LOCAL;

    if (!dx_pos && !dx_neg && !dy_pos && !dy_neg) begin
      cand.fixed = DIR_LOCAL;
    end else if (!dy_pos && !dy_neg) begin
      cand.fixed = cand.x_dir;
    end else if (!dx_pos && !dx_neg) begin
      cand.fixed = cand.y_dir;
    end else if (use_el) begin
      if (dx_pos) cand.fixed = cand.y_dir;
      else        cand.adaptive = 1'b1;
    end else if (use_wf) begin
      if (dx_neg)                              cand.fixed = DIR_WEST;
      else if (mode == MODE_ODD_EVEN && dx_far) cand.fixed = cand.y_dir;
      else                                     cand.adaptive = 1'b1;
    end else begin
      if (dx_neg && dy_pos)      cand.fixed = DIR_WEST;
      else if (dx_pos && dy_neg) cand.fixed = DIR_SOUTH;
      else                       cand.adaptive = 1'b1;
    end
  end
endmodule

// File: rtl/rsel_tiebreak.sv
module rsel_tiebreak #(
  parameter int SW = 4,
  parameter int FW = 4
) (
  input  rsel_pkg::cand_t     cand,
  input  rsel_pkg::dir_e      arrived,
  input  logic [3:0][SW-1:0]  link_used,
  input  logic [3:0][FW-1:0]  nbr_fill,
  output rsel_pkg::dir_e      choice
);
  import rsel_pkg::*;

  logic [1:0]    ix, iy;
  logic [SW-1:0] ux, uy;
  logic [FW-1:0] fx, fy;
  logic          y_straight, pick_y;

  always_comb begin
    ix = 2'(cand.x_dir - 3'd1);
    iy = 2'(cand.y_dir - 3'd1);
    ux = link_used[ix];
    uy = link_used[iy];
    fx = nbr_fill[ix];
    fy = nbr_fill[iy];
    y_straight = (straight_of(arrived) == cand.y_dir);
    if (uy != ux)      pick_y = (uy < ux);
    else if (fy != fx) pick_y = (fy < fx);
    else               pick_y = y_straight;
    if (!cand.adaptive) choice = cand.fixed;
    else                choice = pick_y ? cand.y_dir : cand.x_dir;
  end
endmodule

// File: rtl/route_selector.sv
module route_selector #(
  parameter int XW = 3,
  parameter int YW = 3,
  parameter int SW = 4,
  parameter int FW = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hdr_valid,
  input  logic [XW-1:0]       cur_x,
  input  logic [YW-1:0]       cur_y,
  input  logic [XW-1:0]       dst_x,
  input  logic [YW-1:0]       dst_y,
  input  logic [1:0]          mode,
  input  logic [2:0]          in_port,
  input  logic [3:0][SW-1:0]  link_used,
  input  logic [3:0][FW-1:0]  nbr_fill,
  output logic                sel_valid,
  output logic [2:0]          sel_dir
);
  import rsel_pkg::*;

  logic signed [XW:0] dx;
  logic signed [YW:0] dy;
  cand_t              cand;
  dir_e               choice;

  rsel_axis_delta #(.W(XW)) u_dx (.cur(cur_x), .dst(dst_x), .delta(dx));
  rsel_axis_delta #(.W(YW)) u_dy (.cur(cur_y), .dst(dst_y), .delta(dy));

  rsel_turn_filter #(.XW(XW), .YW(YW)) u_turn (
    .dx(dx), .dy(dy), .col_odd(cur_x[0]), .mode(mode_e'(mode)), .cand(cand)
  );

  rsel_tiebreak #(.SW(SW), .FW(FW)) u_tie (
    .cand(cand), .arrived(dir_e'(in_port)), .link_used(link_used),
    .nbr_fill(nbr_fill), .choice(choice)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid <= 1'b0;
      sel_dir   <= DIR_LOCAL;
    end else begin
      sel_valid <= hdr_valid;
      if (hdr_valid) sel_dir <= choice;
    end
  end
endmodule

// File: rtl/rsel_checker.sv
module rsel_checker #(
  parameter int XW = 3,
  parameter int YW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          hdr_valid,
  input logic [XW-1:0] cur_x,
  input logic [YW-1:0] cur_y,
  input logic [XW-1:0] dst_x,
  input logic [YW-1:0] dst_y,
  input logic [1:0]    mode,
  input logic          sel_valid,
  input logic [2:0]    sel_dir
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!sel_valid && sel_dir == 3'd0));

  // R2
  a_r2_valid_delay: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sel_valid == $past(hdr_valid)));

  a_r2_dir_holds: assert property (@(posedge clk) disable iff (rst)
    !hdr_valid |=> $stable(sel_dir));

  // R3
  a_r3_local_on_arrival: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && cur_x == dst_x && cur_y == dst_y) |=> sel_dir == 3'd0);

  // R4
  a_r4_west_first: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && mode == 2'd0 && dst_x < cur_x) |=> sel_dir == 3'd3);

  // R5
  a_r5_east_last: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && mode == 2'd1 && dst_x > cur_x && dst_y != cur_y)
      |=> sel_dir != 3'd1);

  // R11
  a_r11_no_east_detour: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && dst_x <= cur_x) |=> sel_dir != 3'd1);

  a_r11_no_north_detour: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && dst_y <= cur_y) |=> sel_dir != 3'd2);
endmodule

bind route_selector rsel_checker #(.XW(XW), .YW(YW)) u_chk (
  .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .cur_x(cur_x), .cur_y(cur_y),
  .dst_x(dst_x), .dst_y(dst_y), .mode(mode), .sel_valid(sel_valid),
  .sel_dir(sel_dir)
);

// File: tb/tb_route_selector.sv
module tb_route_selector;
  localparam int XW = 3, YW = 3, SW = 4, FW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hdr_valid = 1'b0;
  logic [XW-1:0] cur_x = '0, dst_x = '0;
  logic [YW-1:0] cur_y = '0, dst_y = '0;
  logic [1:0] mode = '0;
  logic [2:0] in_port = '0;
  logic [3:0][SW-1:0] link_used = '0;
  logic [3:0][FW-1:0] nbr_fill = '0;
  logic sel_valid;
  logic [2:0] sel_dir;

  route_selector #(.XW(XW), .YW(YW), .SW(SW), .FW(FW)) dut (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .cur_x(cur_x), .cur_y(cur_y),
    .dst_x(dst_x), .dst_y(dst_y), .mode(mode), .in_port(in_port),
    .link_used(link_used), .nbr_fill(nbr_fill), .sel_valid(sel_valid),
    .sel_dir(sel_dir)
  );

  always #2 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  int expq[$];
  string tagq[$];
  int last_dir = 0;
  bit have_last = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int opp(input int d);
    case (d)
      1: return 3;
      3: return 1;
      2: return 4;
      4: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int model(input int cx, input int cy, input int tx, input int ty,
                               input int md, input int inp,
                               input logic [3:0][SW-1:0] u, input logic [3:0][FW-1:0] f);
    int dx, dy, xd, yd;
    dx = tx - cx;
    dy = ty - cy;
    if (dx == 0 && dy == 0) return 0;
    if (dy == 0) return (dx > 0) ? 1 : 3;
    if (dx == 0) return (dy > 0) ? 2 : 4;
    xd = (dx > 0) ? 1 : 3;
    yd = (dy > 0) ? 2 : 4;
    if (md == 1 || (md == 2 && cx % 2 == 0)) begin
      if (dx > 0) return yd;
    end else if (md == 0 || md == 2) begin
      if (dx < 0) return 3;
      if (md == 2 && dx > 1) return yd;
    end else begin
      if (dx < 0 && dy > 0) return 3;
      if (dx > 0 && dy < 0) return 4;
    end
    if (u[yd-1] != u[xd-1]) return (u[yd-1] < u[xd-1]) ? yd : xd;
    if (f[yd-1] != f[xd-1]) return (f[yd-1] < f[xd-1]) ? yd : xd;
    return (opp(inp) == yd) ? yd : xd;
  endfunction

  task automatic send(input int cx, input int cy, input int tx, input int ty,
                      input int md, input int inp,
                      input logic [3:0][SW-1:0] u, input logic [3:0][FW-1:0] f,
                      input string tag);
    @(negedge clk);
    cur_x = XW'(cx); cur_y = YW'(cy); dst_x = XW'(tx); dst_y = YW'(ty);
    mode = 2'(md); in_port = 3'(inp); link_used = u; nbr_fill = f;
    hdr_valid = 1'b1;
    expq.push_back(model(cx, cy, tx, ty, md, inp, u, f));
    tagq.push_back(tag);
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (sel_valid) begin
        if (expq.size() == 0) begin
          check(0, "R2 unexpected valid", 1, 0);
        end else begin
          int e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check(sel_dir == 3'(e), t, int'(sel_dir), e);
          last_dir = int'(sel_dir);
          have_last = 1;
        end
      end else if (have_last) begin
        check(int'(sel_dir) == last_dir, "R2 hold while idle", int'(sel_dir), last_dir);
      end
    end
  end

  function automatic logic [3:0][SW-1:0] uv(input int e, input int n, input int w, input int s);
    return {SW'(s), SW'(w), SW'(n), SW'(e)};
  endfunction
  function automatic logic [3:0][FW-1:0] fv(input int e, input int n, input int w, input int s);
    return {FW'(s), FW'(w), FW'(n), FW'(e)};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sel_valid == 1'b0, "R1 reset valid", int'(sel_valid), 0);
    check(sel_dir == 3'd0, "R1 reset dir", int'(sel_dir), 0);
    rst = 1'b0;

    // R3 local and single-axis
    send(3, 3, 3, 3, 0, 0, uv(0,0,0,0), fv(0,0,0,0), "R3 local");
    send(2, 2, 6, 2, 1, 0, uv(9,0,0,0), fv(0,0,0,0), "R3 east only");
    send(2, 5, 2, 1, 3, 0, uv(0,0,0,9), fv(0,0,0,0), "R3 south only");
    send(5, 2, 1, 2, 2, 0, uv(0,0,9,0), fv(0,0,0,0), "R3 west only");
    // R4 west-first
    send(4, 2, 1, 5, 0, 0, uv(0,0,9,9), fv(0,0,9,9), "R4 NW forced west");
    send(2, 2, 5, 5, 0, 0, uv(7,2,0,0), fv(0,0,0,0), "R4 NE adaptive");
    // R5 east-last
    send(2, 2, 5, 5, 1, 0, uv(0,9,0,0), fv(0,0,0,0), "R5 NE takes north");
    send(5, 5, 2, 2, 1, 0, uv(0,0,6,1), fv(0,0,0,0), "R5 SW adaptive");
    // R6 negative-first
    send(4, 2, 1, 5, 3, 0, uv(0,0,9,0), fv(0,0,0,0), "R6 NW west");
    send(1, 5, 4, 2, 3, 0, uv(0,0,0,9), fv(0,0,0,0), "R6 SE south");
    send(1, 1, 4, 4, 3, 0, uv(5,1,0,0), fv(0,0,0,0), "R6 NE adaptive");
    // R7 odd/even
    send(2, 2, 5, 5, 2, 0, uv(0,9,0,0), fv(0,0,0,0), "R7 even east gives Y");
    send(3, 2, 6, 5, 2, 0, uv(0,9,0,0), fv(0,0,0,0), "R7 odd far east gives Y");
    send(3, 2, 4, 5, 2, 0, uv(0,9,0,0), fv(0,0,0,0), "R7 odd near east adaptive");
    send(3, 2, 1, 5, 2, 0, uv(0,0,9,0), fv(0,0,0,0), "R7 odd west forced");
    // R8 slots
    send(1, 1, 4, 4, 0, 0, uv(3,4,0,0), fv(0,0,0,0), "R8 fewer slots east");
    send(1, 1, 4, 4, 0, 0, uv(4,3,0,0), fv(9,0,0,0), "R8 fewer slots north");
    // R9 fifo
    send(1, 1, 4, 4, 0, 0, uv(2,2,0,0), fv(5,4,0,0), "R9 emptier fifo north");
    send(1, 1, 4, 4, 0, 0, uv(2,2,0,0), fv(4,5,0,0), "R9 emptier fifo east");
    // R10 straight / fallback
    send(1, 1, 4, 4, 0, 4, uv(2,2,0,0), fv(3,3,0,0), "R10 straight north");
    send(1, 1, 4, 4, 0, 3, uv(2,2,0,0), fv(3,3,0,0), "R10 straight east");
    send(1, 1, 4, 4, 0, 0, uv(2,2,0,0), fv(3,3,0,0), "R10 local fallback X");
    send(5, 5, 2, 2, 1, 2, uv(0,0,1,1), fv(0,0,1,1), "R10 straight south");
    // Mixed generated requests (R11 minimality covered by model and checker)
    for (int i = 0; i < 600; i++) begin
      logic [3:0][SW-1:0] u;
      logic [3:0][FW-1:0] f;
      for (int k = 0; k < 4; k++) begin
        u[k] = SW'($urandom_range(0, 2));
        f[k] = FW'($urandom_range(0, 2));
      end
      send($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
           $urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 4),
           u, f, "R11 generated");
    end
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R2 all results produced", expq.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      check(0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule